// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This block holds the exception part of a floating-point unit's status and control register and decides when a finished floating-point instruction must trap. Each completed instruction presents a valid strobe together with actual-event indications (invalid operation, divide-by-zero, overflow, underflow, inexact), "may occur" hints for overflow, underflow and inexact, and a denormal-operand indication. From these the block refreshes a per-instruction cause field and accumulates sticky flags.

Software reads the whole register on `csr_rdata` and replaces it with a one-cycle write strobe. An error cause is raised when a denormal operand arrives while the denormal-mode bit is clear. That cause has no enable and no sticky flag, so it always traps. Invalid and divide-by-zero trap when enabled and when the event actually happens. Overflow, underflow and inexact trap when enabled and the instruction only *might* produce the event. A trap shows up as a single-cycle request, one cycle after the instruction, with a reason code.

Top module: `fpx_status_trap`

## Requirements
- R1: While reset is asserted and right after it is released, `csr_rdata` is all zero (including the denormal-mode bit 18), `trap_req` is 0 and `trap_code` is 0.
- R2: A write with `csr_we`=1 and no valid instruction replaces the whole register with `csr_wdata` on the next clock. This includes the rounding bits [1:0], which are stored but have no effect on anything else.
- R3: Cause field bits are [17]=E, [16]=V, [15]=Z, [14]=O, [13]=U, [12]=I. On each valid instruction, every cause bit is 1 if its event occurred and 0 if it did not. Without a valid instruction the cause field holds its value.
- R4: Cause I (bit 12) is set whenever the instruction reports overflow, underflow or inexact.
- R5: Flag bits are [6]=V, [5]=Z, [4]=O, [3]=U, [2]=I. A valid instruction ORs its V, Z, O, U and I causes into the flags. Only a software write can clear a flag.
- R6: Cause E is set exactly when a valid instruction has `op_denorm`=1 while the denormal-mode bit [18] is 0. E never reaches the flags.
- R7: Cause E raises a trap whatever the enables [11:7] hold.
- R8: Enable bits are [11]=V, [10]=Z, [9]=O, [8]=U, [7]=I. Invalid traps when enable V is 1 and `op_inv` is 1. Divide-by-zero traps when enable Z is 1 and `op_dz` is 1.
- R9: Overflow, underflow and inexact trap when their enable is 1 and the matching `op_may_*` hint is 1. An actual event with no hint does not trap.
- R10: `trap_req` is high for exactly the cycle after a trapping instruction. `trap_code` is then E=1, V=2, Z=3, O=4, U=5 or I=6, with the lowest code winning when several sources trap. It is 0 whenever `trap_req` is 0.
- R11: When a write and a valid instruction fall in the same cycle:
  - the instruction's cause update and its flags (old flags OR new causes) take effect;
  - the enables, denormal-mode bit and rounding bits come from the write;
  - the trap decision uses the enables and denormal-mode bit held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A floating-point instruction completes this cycle |
| op_inv | input | 1 | Invalid operation occurred |
| op_dz | input | 1 | Division by zero occurred |
| op_ovf | input | 1 | Overflow occurred |
| op_unf | input | 1 | Underflow occurred |
| op_inx | input | 1 | Rounding made the result inexact |
| op_may_ovf | input | 1 | Instruction may overflow |
| op_may_unf | input | 1 | Instruction may underflow |
| op_may_inx | input | 1 | Instruction may be inexact |
| op_denorm | input | 1 | A denormalized operand was supplied |
| csr_we | input | 1 | Software register write strobe |
| csr_wdata | input | 19 | Software write value |
| csr_rdata | output | 19 | Current register contents |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 3 | Trap reason code |

## Verification
The bench drives an overflow with no hint while every enable is set. A design that traps on the actual event instead of the hint would raise a request there.

It sends a denormal with all enables cleared, to catch a design that masks the error source. It then sends the same denormal with the denormal-mode bit set, which must produce no error.

Several sources are fired together to check priority. A design that ranks them wrongly returns the wrong code.

A write that clears the enables is issued in the same cycle as an invalid operation. A design that lets the write win drops the flag, and a design that uses the new enables misses the trap.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int RM_W    = 2;
    localparam int FLAG_W  = 5;
    localparam int CAUSE_W = FLAG_W + 1;
    localparam int CODE_W  = $clog2(CAUSE_W + 1);
    localparam int CSR_W   = 1 + CAUSE_W + FLAG_W + FLAG_W + RM_W;

    typedef struct packed {
        logic                dn;
        logic [CAUSE_W-1:0]  cause;
        logic [FLAG_W-1:0]   en;
        logic [FLAG_W-1:0]   flag;
        logic [RM_W-1:0]     rm;
    } fpx_csr_t;
endpackage

// File: rtl/fpx_cause_gen.sv
module fpx_cause_gen
    import fpx_pkg::*;
(
    input  logic               dn,
    input  logic               denorm,
    input  logic               inv,
    input  logic               dz,
    input  logic               ovf,
    input  logic               unf,
    input  logic               inx,
    output logic [CAUSE_W-1:0] cause
);
    always_comb begin
        cause = {(denorm & ~dn), inv, dz, ovf, unf, (inx | ovf | unf)};
    end
endmodule

// File: rtl/fpx_trap_sel.sv
module fpx_trap_sel
    import fpx_pkg::*;
(
    input  logic               valid,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [FLAG_W-1:0]  en,
    input  logic               may_ovf,
    input  logic               may_unf,
    input  logic               may_inx,
    output logic               hit,
    output logic [CODE_W-1:0]  code
);
    logic [CAUSE_W-1:0] arm;

    // Bits [CAUSE_W-1:3] use the actual event; the lower three use hints.
    always_comb begin
        arm = '0;
        arm[CAUSE_W-1] = cause[CAUSE_W-1];
        arm[4] = en[4] & cause[4];
        arm[3] = en[3] & cause[3];
        arm[2] = en[2] & may_ovf;
        arm[1] = en[1] & may_unf;
        arm[0] = en[0] & may_inx;
        if (!valid) arm = '0;
    end

    // Higher bit index has higher priority and a lower code.
    always_comb begin
        code = '0;
        for (int i = 0; i < CAUSE_W; i++) begin
            if (arm[i]) code = CODE_W'(CAUSE_W - i);
        end
        hit = |arm;
    end
endmodule

// File: rtl/fpx_status_trap.sv
module fpx_status_trap
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_inv,
    input  logic              op_dz,
    input  logic              op_ovf,
    input  logic              op_unf,
    input  logic              op_inx,
    input  logic              op_may_ovf,
    input  logic              op_may_unf,
    input  logic              op_may_inx,
    input  logic              op_denorm,
    input  logic              csr_we,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_code
);
    typedef struct packed {
        fpx_csr_t            csr;
        logic                trap;
        logic [CODE_W-1:0]   code;
    } state_t;

    state_t             st_d, st_q;
    logic [CAUSE_W-1:0] new_cause;
    logic               hit;
    logic [CODE_W-1:0]  hit_code;

    fpx_cause_gen u_cause (
        .dn     (st_q.csr.dn),
        .denorm (op_denorm),
        .inv    (op_inv),
        .dz     (op_dz),
        .ovf    (op_ovf),
        .unf    (op_unf),
        .inx    (op_inx),
        .cause  (new_cause)
    );

    fpx_trap_sel u_sel (
        .valid   (op_valid),
        .cause   (new_cause),
        .en      (st_q.csr.en),
        .may_ovf (op_may_ovf),
        .may_unf (op_may_unf),
        .may_inx (op_may_inx),
        .hit     (hit),
        .code    (hit_code)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        st_d.code = '0;
        if (csr_we) st_d.csr = fpx_csr_t'(csr_wdata);
        if (op_valid) begin
            st_d.csr.cause = new_cause;
            st_d.csr.flag  = st_q.csr.flag | new_cause[FLAG_W-1:0];
            st_d.trap      = hit;
            st_d.code      = hit_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign csr_rdata = st_q.csr;
    assign trap_req  = st_q.trap;
    assign trap_code = st_q.code;
endmodule

// File: rtl/fpx_status_trap_chk.sv
module fpx_status_trap_chk
    import fpx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_inv,
    input logic              op_ovf,
    input logic              op_denorm,
    input logic              csr_we,
    input logic [CSR_W-1:0]  csr_rdata,
    input logic              trap_req,
    input logic [CODE_W-1:0] trap_code
);
    p_code_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> trap_code == '0);

    p_trap_after_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !trap_req);

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> ((csr_rdata[6:2] & $past(csr_rdata[6:2])) == $past(csr_rdata[6:2])));

    p_err_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_denorm && !csr_rdata[18]) |=> (trap_req && trap_code == 3'd1));

    p_cause_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_inv) |=> !csr_rdata[16]);

    p_inexact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ovf) |=> csr_rdata[12]);
endmodule

bind fpx_status_trap fpx_status_trap_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_inv    (op_inv),
    .op_ovf    (op_ovf),
    .op_denorm (op_denorm),
    .csr_we    (csr_we),
    .csr_rdata (csr_rdata),
    .trap_req  (trap_req),
    .trap_code (trap_code)
);

// File: tb/tb_fpx_status_trap.sv
`timescale 1ns/1ps
module tb_fpx_status_trap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  op = '0;
    logic        csr_we = 1'b0;
    logic [18:0] csr_wdata = '0;
    logic [18:0] csr_rdata;
    logic        trap_req;
    logic [2:0]  trap_code;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [18:0] rd;
        logic        tr;
        logic [2:0]  cd;
        string       tag;
    } exp_t;
    exp_t sb[$];
    logic [18:0] m_reg = '0;

    // op vector: [9]valid [8]inv [7]dz [6]ovf [5]unf [4]inx [3]may_ovf [2]may_unf [1]may_inx [0]denorm
    localparam logic [9:0] NOP = 10'h000, VLD = 10'h200, INV = 10'h100, DZ = 10'h080,
        OVF = 10'h040, UNF = 10'h020, INX = 10'h010, MOV = 10'h008, MUN = 10'h004,
        MIX = 10'h002, DEN = 10'h001;

    always #2 clk = ~clk;

    fpx_status_trap dut (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op[9]), .op_inv(op[8]), .op_dz(op[7]), .op_ovf(op[6]),
        .op_unf(op[5]), .op_inx(op[4]), .op_may_ovf(op[3]), .op_may_unf(op[2]),
        .op_may_inx(op[1]), .op_denorm(op[0]),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .trap_req(trap_req), .trap_code(trap_code)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the reference result.
    task automatic step(input logic [9:0] o, input logic we, input logic [18:0] wd, input string tag);
        logic [5:0]  c;
        logic [5:0]  arm;
        logic [18:0] n;
        logic [2:0]  cd;
        @(negedge clk);
        op = o; csr_we = we; csr_wdata = wd;
        c = {o[0] & ~m_reg[18], o[8], o[7], o[6], o[5], o[4] | o[6] | o[5]};
        arm = {c[5], m_reg[11] & c[4], m_reg[10] & c[3],
               m_reg[9] & o[3], m_reg[8] & o[2], m_reg[7] & o[1]};
        if (!o[9]) arm = '0;
        cd = 3'd0;
        for (int i = 5; i >= 0; i--) if (arm[i] && cd == 3'd0) cd = 3'(6 - i);
        n = we ? wd : m_reg;
        if (o[9]) begin
            n[17:12] = c;
            n[6:2]   = m_reg[6:2] | c[4:0];
        end
        m_reg = n;
        sb.push_back('{rd: n, tr: (cd != 0), cd: cd, tag: tag});
    endtask

    // Monitor: pops the expected item for each clock after the driver queued it.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " csr"},  32'(csr_rdata), 32'(e.rd));
            check({e.tag, " trap"}, 32'(trap_req),  32'(e.tr));
            check({e.tag, " code"}, 32'(trap_code), 32'(e.cd));
        end
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset csr",  32'(csr_rdata), 0);
        check("R1 reset trap", 32'(trap_req), 0);
        check("R1 reset code", 32'(trap_code), 0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 post-reset csr", 32'(csr_rdata), 0);

        step(NOP, 1'b1, 19'h00003, "R2 write rm");
        step(VLD | OVF, 1'b0, '0, "R4 ovf sets inexact");
        step(VLD | INV, 1'b0, '0, "R3 R5 cause clears, flags stay");
        step(NOP, 1'b0, '0, "R3 idle holds");
        step(VLD | DEN, 1'b0, '0, "R6 R7 error traps with no enables");
        step(NOP, 1'b1, 19'h40000, "R2 set denormal mode");
        step(VLD | DEN, 1'b0, '0, "R6 no error when mode set");
        step(NOP, 1'b1, 19'h00F80, "R2 enable all");
        step(VLD | INV | DZ, 1'b0, '0, "R8 R10 invalid beats dz");
        step(VLD | DZ, 1'b0, '0, "R8 dz trap");
        step(VLD | OVF | UNF | INX, 1'b0, '0, "R9 actual without hint no trap");
        step(VLD | MOV | MUN | MIX, 1'b0, '0, "R9 R10 may-ovf code");
        step(VLD | MUN | MIX, 1'b0, '0, "R9 may-unf code");
        step(VLD | MIX, 1'b0, '0, "R9 may-inx code");
        step(VLD | DEN | INV | MOV, 1'b0, '0, "R10 error top priority");
        step(VLD | DZ, 1'b0, '0, "R10 back to back");
        step(NOP, 1'b0, '0, "R10 pulse ends");
        step(VLD | INV, 1'b1, 19'h00000, "R11 collision");
        step(VLD | INV, 1'b0, '0, "R11 new enables apply");
        step(NOP, 1'b1, 19'h00002, "R5 write clears flags");
        step(NOP, 1'b0, '0, "R5 cleared flags hold");
        repeat (3) @(posedge clk);
        #1;
        check("scoreboard drained", 32'(sb.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule